// File: doc/BRIEF.md
# Trimmable Real-Time Clock

This peripheral keeps time in whole seconds from a 32.768 kHz reference clock. A prescaler counts reference cycles. It emits a one-cycle tick each time it reaches a programmable divide count, so a divide count of D gives one tick every D+1 cycles. A trim field corrects slow drift. Once per trim interval, the prescaler shortens a single period by the trim amount. If the whole divide/trim register is zero, the prescaler uses a built-in default divide count instead.

Each tick advances a 32-bit seconds counter. When the counter becomes equal to a 32-bit alarm value, the block flags an alarm event. The alarm event and the tick event each latch a pending flag in a status register, which also holds one enable bit per source. Each event drives its own interrupt line. That line is high while the source's pending flag and its enable bit are both set.

Software reaches the four registers through a plain synchronous word bus. A write takes effect on the clock edge. A read returns data in the same cycle as the address.

Top module: `rtc_timekeeper`

## Requirements
- R1: The word offsets are 0 for divide/trim, 1 for seconds, 2 for alarm and 3 for status. Read data follows the address in the same cycle. After reset, all four registers read zero and both interrupt lines are low.
- R2: With a nonzero divide/trim register and divide count D (bits 15:0), a tick occurs every D+1 clock cycles. Each tick adds one to the seconds counter, which wraps from all-ones to zero.
- R3: When the whole divide/trim register is zero, the divide count 32767 is used. The seconds counter then advances once every 32768 cycles.
- R4: The trim value N sits in bits 16 and up, and the register reads back as written. Counting ticks from the last seconds write, the period that ends with tick number TRIM_SECS is N cycles shorter, and this repeats every TRIM_SECS ticks. The default TRIM_SECS is 1024.
- R5: A seconds write loads the written value, which reads back after the write edge. The same write restarts the prescaler and the trim phase, so the next increment lands D+1 edges after the write edge.
- R6: One cycle after the seconds counter becomes equal to the alarm register, status bit 0 (alarm pending) is set.
- R7: Status bit 1 is 1 Hz pending, bit 2 is alarm enable and bit 3 is 1 Hz enable. Writing a one to a pending bit clears it, and writing a zero leaves it unchanged. Both enable bits take the written value. If an event arrives in the same cycle as a clearing write, the event wins.
- R8: Every tick sets status bit 1, whatever the 1 Hz enable bit holds.
- R9: The alarm interrupt output is high exactly while bits 0 and 2 are both set. The 1 Hz interrupt output is high exactly while bits 1 and 3 are both set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32.768 kHz reference clock, also the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write qualifier for bus_sel |
| bus_addr | input | 2 | Word offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_alarm | output | 1 | Alarm interrupt request |
| irq_hz | output | 1 | 1 Hz interrupt request |

## Verification
The bench builds the block with TRIM_SECS set to 4 and keeps every other parameter at its default. The shorter trim interval puts a shortened period within a few dozen cycles, so the exact edge where the trim takes effect can be checked. The default divide count stays at 32767, which lets the bench measure the full 32768-cycle fall-back period directly. Small divide counts, written through the bus, exercise the tick cadence, counter wrap, alarm matching and pending/enable interplay in short runs.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    typedef enum logic [1:0] {
        REG_DIVTRIM = 2'd0,
        REG_SECONDS = 2'd1,
        REG_ALARM   = 2'd2,
        REG_STATUS  = 2'd3
    } rtc_reg_e;

    // event source indices; enable of source i sits at status bit i + SRC_COUNT
    localparam int unsigned SRC_ALARM = 0;
    localparam int unsigned SRC_HZ    = 1;
    localparam int unsigned SRC_COUNT = 2;
endpackage

// File: rtl/rtc_prescale.sv
module rtc_prescale #(
    parameter int DIV_W       = 16,
    parameter int TRIM_W      = 8,
    parameter int DEFAULT_DIV = 32767,
    parameter int TRIM_SECS   = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  div_val,
    input  logic [TRIM_W-1:0] trim_val,
    input  logic              use_default,
    input  logic              restart,
    output logic              tick
);
    localparam int PH_W = (TRIM_SECS > 1) ? $clog2(TRIM_SECS) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(TRIM_SECS - 1);

    typedef struct packed {
        logic [DIV_W-1:0] pre;
        logic [PH_W-1:0]  phase;
    } pre_state_t;

    pre_state_t s_d, s_q;
    logic [DIV_W-1:0] base_div;
    logic [DIV_W-1:0] trim_ext;
    logic [DIV_W-1:0] limit;
    logic             trim_slot;

    always_comb begin
        base_div  = use_default ? DIV_W'(DEFAULT_DIV) : div_val;
        trim_ext  = use_default ? '0 : DIV_W'(trim_val);
        trim_slot = (s_q.phase == PH_LAST);
        limit     = base_div;
        if (trim_slot) begin
            limit = (base_div > trim_ext) ? (base_div - trim_ext) : '0;
        end
        tick = (s_q.pre >= limit) && !restart;

        s_d = s_q;
        if (restart) begin
            s_d.pre   = '0;
            s_d.phase = '0;
        end else if (tick) begin
            s_d.pre   = '0;
            s_d.phase = trim_slot ? '0 : s_q.phase + 1'b1;
        end else begin
            s_d.pre = s_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end
endmodule

// File: rtl/rtc_count_alarm.sv
module rtc_count_alarm #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             cnt_wr,
    input  logic             alarm_wr,
    input  logic [CNT_W-1:0] wval,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] alarm,
    output logic             alarm_hit
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] alarm;
        logic             match;
    } ca_state_t;

    ca_state_t s_d, s_q;
    logic      equal_now;

    always_comb begin
        equal_now = (s_q.count == s_q.alarm);
        alarm_hit = equal_now && !s_q.match;

        s_d       = s_q;
        s_d.match = equal_now;
        if (cnt_wr)    s_d.count = wval;
        else if (tick) s_d.count = s_q.count + 1'b1;
        if (alarm_wr)  s_d.alarm = wval;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q       <= '0;
            s_q.match <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign count = s_q.count;
    assign alarm = s_q.alarm;
endmodule

// File: rtl/rtc_status.sv
module rtc_status #(
    parameter int NSRC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              st_wr,
    input  logic [2*NSRC-1:0] wbits,
    input  logic [NSRC-1:0]   event_in,
    output logic [NSRC-1:0]   pend,
    output logic [NSRC-1:0]   en,
    output logic [NSRC-1:0]   irq
);
    typedef struct packed {
        logic [NSRC-1:0] en;
        logic [NSRC-1:0] pend;
    } st_state_t;

    st_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (st_wr) begin
            s_d.pend = s_q.pend & ~wbits[NSRC-1:0];
            s_d.en   = wbits[2*NSRC-1:NSRC];
        end
        s_d.pend = s_d.pend | event_in;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_irq
        assign irq[i] = s_q.pend[i] & s_q.en[i];
    end

    assign pend = s_q.pend;
    assign en   = s_q.en;
endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper #(
    parameter int DATA_W      = 32,
    parameter int DIV_W       = 16,
    parameter int TRIM_W      = 8,
    parameter int DEFAULT_DIV = 32767,
    parameter int TRIM_SECS   = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_alarm,
    output logic              irq_hz
);
    import rtc_pkg::*;

    localparam int DT_W = DIV_W + TRIM_W;

    typedef struct packed {
        logic [DT_W-1:0] divtrim;
    } top_state_t;

    top_state_t s_d, s_q;

    rtc_reg_e                 reg_sel;
    logic                     dt_wr, cnt_wr, alarm_wr, st_wr;
    logic                     tick, alarm_hit;
    logic [DATA_W-1:0]        count_val, alarm_val;
    logic [SRC_COUNT-1:0]     pend, en, irq, events;
    logic                     al_pend, hz_pend, al_en, hz_en;

    always_comb begin
        reg_sel  = rtc_reg_e'(bus_addr);
        dt_wr    = bus_sel && bus_wr && (reg_sel == REG_DIVTRIM);
        cnt_wr   = bus_sel && bus_wr && (reg_sel == REG_SECONDS);
        alarm_wr = bus_sel && bus_wr && (reg_sel == REG_ALARM);
        st_wr    = bus_sel && bus_wr && (reg_sel == REG_STATUS);

        s_d = s_q;
        if (dt_wr) s_d.divtrim = bus_wdata[DT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    rtc_prescale #(
        .DIV_W       (DIV_W),
        .TRIM_W      (TRIM_W),
        .DEFAULT_DIV (DEFAULT_DIV),
        .TRIM_SECS   (TRIM_SECS)
    ) u_prescale (
        .clk         (clk),
        .rst         (rst),
        .div_val     (s_q.divtrim[DIV_W-1:0]),
        .trim_val    (s_q.divtrim[DT_W-1:DIV_W]),
        .use_default (s_q.divtrim == '0),
        .restart     (cnt_wr),
        .tick        (tick)
    );

    rtc_count_alarm #(
        .CNT_W (DATA_W)
    ) u_count (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .cnt_wr    (cnt_wr),
        .alarm_wr  (alarm_wr),
        .wval      (bus_wdata),
        .count     (count_val),
        .alarm     (alarm_val),
        .alarm_hit (alarm_hit)
    );

    always_comb begin
        events            = '0;
        events[SRC_ALARM] = alarm_hit;
        events[SRC_HZ]    = tick;
    end

    rtc_status #(
        .NSRC (SRC_COUNT)
    ) u_status (
        .clk      (clk),
        .rst      (rst),
        .st_wr    (st_wr),
        .wbits    (bus_wdata[2*SRC_COUNT-1:0]),
        .event_in (events),
        .pend     (pend),
        .en       (en),
        .irq      (irq)
    );

    assign al_pend   = pend[SRC_ALARM];
    assign hz_pend   = pend[SRC_HZ];
    assign al_en     = en[SRC_ALARM];
    assign hz_en     = en[SRC_HZ];
    assign irq_alarm = irq[SRC_ALARM];
    assign irq_hz    = irq[SRC_HZ];

    always_comb begin
        case (reg_sel)
            REG_DIVTRIM: bus_rdata = DATA_W'(s_q.divtrim);
            REG_SECONDS: bus_rdata = count_val;
            REG_ALARM:   bus_rdata = alarm_val;
            REG_STATUS:  bus_rdata = DATA_W'({en, pend});
            default:     bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/rtc_timekeeper_chk.sv
module rtc_timekeeper_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic              cnt_wr,
    input logic              st_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] count_val,
    input logic [DATA_W-1:0] alarm_val,
    input logic              al_pend,
    input logic              hz_pend,
    input logic              al_en,
    input logic              hz_en,
    input logic              irq_alarm,
    input logic              irq_hz
);
    // R2
    tick_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !cnt_wr) |=> (count_val == $past(count_val) + 1'b1));

    // R5
    seconds_load_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> (count_val == $past(bus_wdata)));

    // R8
    hz_latch_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> hz_pend);

    // R6
    alarm_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (count_val != alarm_val) ##1 (count_val == alarm_val) |=> al_pend);

    // R7
    enable_load_chk: assert property (@(posedge clk) disable iff (rst)
        st_wr |=> ((al_en == $past(bus_wdata[2])) && (hz_en == $past(bus_wdata[3]))));

    // R9
    alarm_irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        irq_alarm |-> (al_pend && al_en));

    // R9
    hz_irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        irq_hz |-> (hz_pend && hz_en));
endmodule

bind rtc_timekeeper rtc_timekeeper_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .cnt_wr    (cnt_wr),
    .st_wr     (st_wr),
    .bus_wdata (bus_wdata),
    .count_val (count_val),
    .alarm_val (alarm_val),
    .al_pend   (al_pend),
    .hz_pend   (hz_pend),
    .al_en     (al_en),
    .hz_en     (hz_en),
    .irq_alarm (irq_alarm),
    .irq_hz    (irq_hz)
);

// File: tb/rtc_timekeeper_test.sv
`timescale 1ns/10ps
module rtc_timekeeper_test;
    localparam int TB_TRIM_SECS = 4;
    localparam logic [1:0] A_DT = 2'd0, A_SEC = 2'd1, A_ALM = 2'd2, A_ST = 2'd3;
    localparam int NVEC = 5;
    localparam logic [31:0] VEC_DIV   [NVEC] = '{32'd1, 32'd3, 32'd6, 32'd10, 32'd25};
    localparam logic [31:0] VEC_START [NVEC] = '{32'd100, 32'd2000, 32'hFFFF_FFFF, 32'd77, 32'd5};
    localparam int          VEC_PER   [NVEC] = '{2, 4, 7, 11, 26};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_alarm, irq_hz;

    int checks = 0, errors = 0, el = 0;
    bit done = 1'b0;
    logic [31:0] rv;

    always #2 clk = ~clk;

    rtc_timekeeper #(.TRIM_SECS(TB_TRIM_SECS)) uut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_alarm(irq_alarm), .irq_hz(irq_hz)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        el = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.1;
        d = bus_rdata;
    endtask

    // advance to the negedge after edge n, counted from the last write edge
    task automatic go(input int n);
        repeat (n - el) @(negedge clk);
        el = n;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        #800000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(A_DT, rv);  check("R1 divtrim", rv, 32'h0);
        rd(A_SEC, rv); check("R1 seconds", rv, 32'h0);
        rd(A_ALM, rv); check("R1 alarm", rv, 32'h0);
        rd(A_ST, rv);  check("R1 status", rv, 32'h0);
        check("R1 irqs", {30'h0, irq_alarm, irq_hz}, 32'h0);

        // R2 / R5 cadence table
        for (int i = 0; i < NVEC; i++) begin
            wr(A_DT, VEC_DIV[i]);
            wr(A_SEC, VEC_START[i]);
            rd(A_SEC, rv); check("R5 seconds readback", rv, VEC_START[i]);
            go(VEC_PER[i] - 1);
            rd(A_SEC, rv); check("R5 no early tick", rv, VEC_START[i]);
            go(VEC_PER[i]);
            rd(A_SEC, rv); check("R2 first tick", rv, VEC_START[i] + 32'd1);
            go(2 * VEC_PER[i] - 1);
            rd(A_SEC, rv); check("R2 hold", rv, VEC_START[i] + 32'd1);
            go(2 * VEC_PER[i]);
            rd(A_SEC, rv); check("R2 second tick", rv, VEC_START[i] + 32'd2);
        end

        // R8 pending without enable
        rd(A_ST, rv); check("R8 hz pending set", rv & 32'h2, 32'h2);
        check("R8 irq_hz low while disabled", {31'h0, irq_hz}, 32'h0);

        // R4 trim: period 10, trim 2, fourth period shortened to 8
        wr(A_DT, 32'h0002_0009);
        rd(A_DT, rv); check("R4 divtrim readback", rv, 32'h0002_0009);
        wr(A_SEC, 32'd0);
        go(9);  rd(A_SEC, rv); check("R4 period1 hold", rv, 32'd0);
        go(10); rd(A_SEC, rv); check("R4 period1", rv, 32'd1);
        go(37); rd(A_SEC, rv); check("R4 before short", rv, 32'd3);
        go(38); rd(A_SEC, rv); check("R4 shortened", rv, 32'd4);
        go(47); rd(A_SEC, rv); check("R4 full again hold", rv, 32'd4);
        go(48); rd(A_SEC, rv); check("R4 full again", rv, 32'd5);

        // R6 / R9 alarm
        wr(A_DT, 32'd3);
        wr(A_ALM, 32'd5000);
        wr(A_ST, 32'h7);
        wr(A_SEC, 32'd4998);
        go(8); rd(A_ST, rv); check("R6 not yet pending", rv & 32'h1, 32'h0);
        check("R9 irq_alarm low", {31'h0, irq_alarm}, 32'h0);
        go(9); rd(A_ST, rv); check("R6 alarm pending", rv & 32'h1, 32'h1);
        check("R9 irq_alarm high", {31'h0, irq_alarm}, 32'h1);
        check("R9 irq_hz gated", {31'h0, irq_hz}, 32'h0);

        // R7 write-one-to-clear, no ticks during this window
        wr(A_DT, 32'd1000);
        wr(A_SEC, 32'd0);
        rd(A_ST, rv); check("R7 status layout", rv, 32'h7);
        wr(A_ST, 32'h0);
        rd(A_ST, rv); check("R7 zero keeps pending", rv, 32'h3);
        check("R9 irq_alarm off with enable", {31'h0, irq_alarm}, 32'h0);
        wr(A_ST, 32'h9);
        rd(A_ST, rv); check("R7 clear alarm, set hz en", rv, 32'hA);
        check("R9 irq_hz high", {31'h0, irq_hz}, 32'h1);
        wr(A_ST, 32'hE);
        rd(A_ST, rv); check("R7 clear hz pending", rv, 32'hC);
        check("R9 irq_hz low after clear", {31'h0, irq_hz}, 32'h0);

        // R3 default divide
        wr(A_DT, 32'h0);
        rd(A_DT, rv); check("R3 divtrim zero", rv, 32'h0);
        wr(A_SEC, 32'd5);
        go(32767); rd(A_SEC, rv); check("R3 default hold", rv, 32'd5);
        go(32768); rd(A_SEC, rv); check("R3 default tick", rv, 32'd6);
        rd(A_ST, rv); check("R8 tick sets pending", rv, 32'hE);

        // R1 reset again from a loaded state
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        rd(A_DT, rv);  check("R1 divtrim after reset", rv, 32'h0);
        rd(A_SEC, rv); check("R1 seconds after reset", rv, 32'h0);
        rd(A_ALM, rv); check("R1 alarm after reset", rv, 32'h0);
        rd(A_ST, rv);  check("R1 status after reset", rv, 32'h0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule